// File: doc/BRIEF.md
# Serial Control Port with Interface Latches

This block is the configuration port of a mixed-signal device. A host drives a control clock, an active-low select and a serial data line; every framed transfer carries one instruction byte followed by one data byte. The instruction byte decides whether the data byte is written into the register file or read back out on the serial output. The register file holds a control byte (its lowest bit powers the device up), a transmit gain byte, a receive gain byte, a hybrid balance byte, a per-pin direction register and a latch register for a small bank of general-purpose pins.

The control clock is unrelated to the system clock. Select, control clock and serial input are brought into the system clock domain through two-flop synchronizers, and all register updates happen there. A pin whose direction bit is 1 is an output and shows the latch register bit. A pin whose direction bit is 0 is an input: every complete write transfer copies its level into the latch register, so the host can read it later. An active-low power-on reset and an active-high master reset both return every register to its default. For one bidirectional data pin, tie the serial input to the pad and drive the pad from the serial output while the output enable is high.

Top module: `serial_ctl_port`

## Requirements
- R1: While `por_n` is low or `mrst` is high, all registers are forced to zero: gains, hybrid and control read 0, `pwr_up` is 0 (powered down), every direction bit is 0 so `lat_oe` is all zero, and `sdo_oe` is 0.
- R2: A transfer is 16 control-clock cycles with `csn` low. `sdi` is sampled on rising `sclk`, most significant bit first. Instruction bit 7 is the read flag (1 = read), bits 6:3 are the address, and bits 2:0 are ignored. With `csn` high, no register changes.
- R3: On a complete write, the data byte goes to address 0 (control, bit 0 = `pwr_up`), 1 (`tx_gain`), 2 (`rx_gain`), 3 (`hyb`), 4 (direction, low LW bits) or 5 (latch, low LW bits). Each register appears at its output port.
- R4: A read returns the addressed register on `sdo`, most significant bit first. Each bit changes after a falling `sclk` and is valid at the next rising edge. Bits above LW of the direction and latch registers read 0.
- R5: `sdo_oe` is high only during the data byte of a read while the port is selected. It is low in the instruction byte, in every write, and after `csn` rises.
- R6: `lat_oe[i]` equals direction bit i (1 = output).
- R7: For every output pin, `lat_out[i]` shows the latch bit last written through address 5.
- R8: Every complete write, to any address, copies `lat_in[i]` into latch bit i for each input pin. Output pins take the written data if the address is 5 and otherwise keep their value.
- R9: A read does not capture `lat_in`. The latch register keeps its value.
- R10: If `csn` rises before the 16th rising `sclk`, the transfer is discarded and every register is left unchanged.
- R11: Addresses 6 to 15 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low |
| mrst | input | 1 | Master reset, active high |
| sclk | input | 1 | Control clock, asynchronous to `clk` |
| csn | input | 1 | Port select, active low |
| sdi | input | 1 | Serial control data in |
| sdo | output | 1 | Serial read data out |
| sdo_oe | output | 1 | Drive enable for `sdo` |
| lat_in | input | LW | Levels sensed on the latch pins |
| lat_out | output | LW | Latch register, driven onto output pins |
| lat_oe | output | LW | Per-pin output enable (direction register) |
| ctrl | output | 8 | Control register |
| tx_gain | output | 8 | Transmit gain register |
| rx_gain | output | 8 | Receive gain register |
| hyb | output | 8 | Hybrid balance register |
| pwr_up | output | 1 | Power-up state, control bit 0 |

## Verification
A bit counter that slips by one position would shift the address or data field. This shows within a single transfer, either as a wrong value on a register port or as the wrong bit on `sdo` at the first data sample. A direction register that is corrupted shows on `lat_oe` at once. It also shows on the next write, because input bits and output bits of the latch then mix in the wrong way. A commit that fires too early shows when a partial transfer changes a register port a few system clocks after its last rising `sclk`.

// File: rtl/serial_ctl_port.sv
module serial_ctl_port #(
  parameter int LW = 5
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          mrst,
  input  logic          sclk,
  input  logic          csn,
  input  logic          sdi,
  output logic          sdo,
  output logic          sdo_oe,
  input  logic [LW-1:0] lat_in,
  output logic [LW-1:0] lat_out,
  output logic [LW-1:0] lat_oe,
  output logic [7:0]    ctrl,
  output logic [7:0]    tx_gain,
  output logic [7:0]    rx_gain,
  output logic [7:0]    hyb,
  output logic          pwr_up
);
  localparam logic [3:0] A_CTRL = 4'd0, A_TXG = 4'd1, A_RXG = 4'd2,
                         A_HYB = 4'd3, A_DIR = 4'd4, A_LAT = 4'd5;
  localparam int CW = 5;

  logic          rst;
  logic [2:0]    sc_s;
  logic [1:0]    cs_s, di_s;
  logic [CW-1:0] cnt;
  logic [6:0]    sh;
  logic [4:0]    inst;
  logic [7:0]    dout, rdv;
  logic [LW-1:0] dir, lat;
  logic [7:0]    nb;
  logic          act, rise, fall, wr_go;

  assign rst   = mrst | ~por_n;
  assign act   = ~cs_s[1];
  assign rise  = sc_s[1] & ~sc_s[2];
  assign fall  = ~sc_s[1] & sc_s[2];
  assign nb    = {sh, di_s[1]};
  assign wr_go = act & rise & (cnt == CW'(15)) & ~inst[4];

  always_ff @(posedge clk or posedge rst)
    if (rst) begin
      sc_s <= '0;
      cs_s <= 2'b11;
      di_s <= '0;
    end else begin
      sc_s <= {sc_s[1:0], sclk};
      cs_s <= {cs_s[0], csn};
      di_s <= {di_s[0], sdi};
    end

  always_comb
    case (nb[6:3])
      A_CTRL:  rdv = ctrl;
      A_TXG:   rdv = tx_gain;
      A_RXG:   rdv = rx_gain;
      A_HYB:   rdv = hyb;
      A_DIR:   rdv = 8'(dir);
      A_LAT:   rdv = 8'(lat);
      default: rdv = 8'h00;
    endcase

  always_ff @(posedge clk or posedge rst)
    if (rst) begin
      cnt  <= '0;
      sh   <= '0;
      inst <= '0;
      dout <= '0;
    end else if (!act) begin
      cnt <= '0;
    end else begin
      if (rise && cnt < CW'(16)) begin
        sh  <= nb[6:0];
        cnt <= cnt + CW'(1);
        if (cnt == CW'(7)) begin
          inst <= nb[7:3];
          if (nb[7]) dout <= rdv;
        end
      end
      if (fall && cnt >= CW'(9) && cnt <= CW'(15))
        dout <= {dout[6:0], 1'b0};
    end

  always_ff @(posedge clk or posedge rst)
    if (rst) begin
      ctrl    <= '0;
      tx_gain <= '0;
      rx_gain <= '0;
      hyb     <= '0;
      dir     <= '0;
      lat     <= '0;
    end else if (wr_go) begin
      case (inst[3:0])
        A_CTRL: ctrl    <= nb;
        A_TXG:  tx_gain <= nb;
        A_RXG:  rx_gain <= nb;
        A_HYB:  hyb     <= nb;
        A_DIR:  dir     <= nb[LW-1:0];
        default: ;
      endcase
      lat <= (((inst[3:0] == A_LAT) ? nb[LW-1:0] : lat) & dir) | (lat_in & ~dir);
    end

  assign sdo     = dout[7];
  assign sdo_oe  = act & inst[4] & (cnt >= CW'(8)) & (cnt < CW'(16));
  assign lat_out = lat;
  assign lat_oe  = dir;
  assign pwr_up  = ctrl[0];
endmodule

module serial_ctl_port_chk #(
  parameter int LW = 5
) (
  input logic          clk,
  input logic          por_n,
  input logic          mrst,
  input logic          csn,
  input logic          sdo_oe,
  input logic [LW-1:0] lat_out,
  input logic [LW-1:0] lat_oe,
  input logic [7:0]    ctrl,
  input logic [7:0]    tx_gain,
  input logic [7:0]    rx_gain,
  input logic [7:0]    hyb
);
  logic rst;
  assign rst = mrst | ~por_n;

  // R1
  reset_dflt_chk: assert property (@(posedge clk)
    $past(rst) |-> (ctrl == 8'h00 && tx_gain == 8'h00 && rx_gain == 8'h00 &&
                    hyb == 8'h00 && lat_oe == '0 && !sdo_oe));

  // R5
  oe_sel_chk: assert property (@(posedge clk) disable iff (rst)
    sdo_oe |-> !$past(csn, 2));

  // R2
  idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
    $past(csn, 3) |-> ($stable(ctrl) && $stable(tx_gain) && $stable(rx_gain) &&
                       $stable(hyb) && $stable(lat_out)));

  // R6
  dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(lat_oe) |-> !$past(csn, 3));
endmodule

bind serial_ctl_port serial_ctl_port_chk #(.LW(LW)) u_chk (
  .clk(clk), .por_n(por_n), .mrst(mrst), .csn(csn), .sdo_oe(sdo_oe),
  .lat_out(lat_out), .lat_oe(lat_oe), .ctrl(ctrl), .tx_gain(tx_gain),
  .rx_gain(rx_gain), .hyb(hyb)
);

// File: tb/tb_serial_ctl_port.sv
module tb_serial_ctl_port;
  localparam int LW = 5;
  logic clk = 0, por_n = 0, mrst = 0, sclk = 0, csn = 1, sdi = 0;
  logic sdo, sdo_oe, pwr_up;
  logic [LW-1:0] lat_in = '0, lat_out, lat_oe;
  logic [7:0] ctrl, tx_gain, rx_gain, hyb;
  int total = 0, bad = 0;
  logic oe_all, oe_any_inst;

  always #10 clk = ~clk;

  serial_ctl_port #(.LW(LW)) dut (
    .clk(clk), .por_n(por_n), .mrst(mrst), .sclk(sclk), .csn(csn), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .lat_in(lat_in), .lat_out(lat_out),
    .lat_oe(lat_oe), .ctrl(ctrl), .tx_gain(tx_gain), .rx_gain(rx_gain),
    .hyb(hyb), .pwr_up(pwr_up)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] ib, input logic [7:0] db, input int nbits,
                      output logic [7:0] rd);
    rd = '0;
    oe_all = 1'b1;
    oe_any_inst = 1'b0;
    csn = 0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 8) ? ib[7-i] : db[15-i];
      repeat (8) @(negedge clk);
      if (i >= 8) begin
        rd[15-i] = sdo;
        if (!sdo_oe) oe_all = 1'b0;
      end else if (sdo_oe) oe_any_inst = 1'b1;
      sclk = 1;
      repeat (8) @(negedge clk);
      sclk = 0;
    end
    repeat (8) @(negedge clk);
    csn = 1;
    repeat (8) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    logic [7:0] x;
    xfer({1'b0, a, 3'b000}, d, 16, x);
  endtask

  task automatic rdr(input logic [3:0] a, output logic [7:0] d);
    xfer({1'b1, a, 3'b000}, 8'h00, 16, d);
  endtask

  function automatic logic [7:0] pat(input int k);
    return 8'((k * 37 + 11) ^ (k << 4));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] r, g;
    logic [LW-1:0] m_lat, m_dir;
    repeat (4) @(negedge clk);
    por_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset defaults
    chk("R1 ctrl", ctrl, 0); chk("R1 tx", tx_gain, 0); chk("R1 rx", rx_gain, 0);
    chk("R1 hyb", hyb, 0); chk("R1 oe", lat_oe, 0); chk("R1 pwr", pwr_up, 0);
    chk("R1 sdo_oe", sdo_oe, 0);

    // R2 R3 R4 R5 register write/read sweep
    for (int a = 0; a < 4; a++)
      for (int k = 0; k < 6; k++) begin
        g = pat(a * 6 + k);
        wr(4'(a), g);
        case (a)
          0: begin chk("R3 ctrl", ctrl, g); chk("R3 pwr_up", pwr_up, g[0]); end
          1: chk("R3 tx_gain", tx_gain, g);
          2: chk("R3 rx_gain", rx_gain, g);
          default: chk("R3 hyb", hyb, g);
        endcase
        chk("R5 write no oe", oe_any_inst, 0);
        rdr(4'(a), r);
        chk("R4 readback", r, g);
        chk("R5 oe in data", oe_all, 1);
        chk("R5 oe not in instr", oe_any_inst, 0);
        chk("R5 oe after", sdo_oe, 0);
      end

    // R2 reserved instruction bits ignored
    xfer(8'b0_0001_101, 8'h3C, 16, r);
    chk("R2 reserved", tx_gain, 8'h3C);

    // R6 R7 R8 direction and latch sweep
    m_lat = lat_out;
    for (int dv = 0; dv < (1 << LW); dv++) begin
      lat_in = LW'(dv * 7 ^ 5);
      wr(4'd4, 8'(dv));
      m_lat = (m_lat & m_dir) | (lat_in & ~m_dir);
      m_dir = LW'(dv);
      chk("R6 lat_oe", lat_oe, m_dir);
      rdr(4'd4, r);
      chk("R4 dir read", r, 8'(m_dir));
      lat_in = LW'(dv * 11 + 9);
      g = 8'(dv * 13 + 3);
      wr(4'd5, g);
      m_lat = (g[LW-1:0] & m_dir) | (lat_in & ~m_dir);
      chk("R7 lat_out", lat_out & m_dir, m_lat & m_dir);
      rdr(4'd5, r);
      chk("R8 lat read", r, 8'(m_lat));
    end

    // R8 capture on write to another address
    wr(4'd4, 8'h03);
    m_dir = 5'b00011;
    m_lat = lat_out;
    lat_in = 5'b10101;
    wr(4'd1, 8'h77);
    m_lat = (m_lat & m_dir) | (lat_in & ~m_dir);
    rdr(4'd5, r);
    chk("R8 capture other addr", r, 8'(m_lat));

    // R9 read does not capture
    lat_in = 5'b01010;
    rdr(4'd5, r);
    chk("R9 read no capture", r, 8'(m_lat));
    rdr(4'd5, r);
    chk("R9 latch kept", r, 8'(m_lat));

    // R10 early termination
    for (int n = 4; n < 16; n += 5) begin
      xfer({1'b0, 4'd1, 3'b000}, 8'hE1, n, r);
      chk("R10 tx kept", tx_gain, 8'h77);
      rdr(4'd5, r);
      chk("R10 lat kept", r, 8'(m_lat));
    end
    xfer({1'b0, 4'd4, 3'b000}, 8'h1C, 15, r);
    chk("R10 dir kept", lat_oe, m_dir);

    // R11 unused addresses
    for (int a = 6; a < 16; a++) begin
      rdr(4'(a), r);
      chk("R11 read zero", r, 0);
    end
    lat_in = 5'b00000;
    r = ctrl; g = hyb;
    wr(4'd9, 8'hFF);
    chk("R11 ctrl", ctrl, r); chk("R11 hyb", hyb, g); chk("R11 tx", tx_gain, 8'h77);
    chk("R11 dir", lat_oe, m_dir);

    // R1 master reset
    wr(4'd0, 8'h01);
    wr(4'd4, 8'h1F);
    chk("R1 pre", pwr_up, 1);
    mrst = 1;
    repeat (3) @(negedge clk);
    mrst = 0;
    repeat (3) @(negedge clk);
    chk("R1 mrst ctrl", ctrl, 0); chk("R1 mrst tx", tx_gain, 0);
    chk("R1 mrst rx", rx_gain, 0); chk("R1 mrst oe", lat_oe, 0);
    chk("R1 mrst lat", lat_out, 0); chk("R1 mrst pwr", pwr_up, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule